// File: doc/BRIEF.md
# Port Status Blink-Code LED Driver

This block turns the state of one powered Ethernet port into the drive for a single status LED. While the port is powered the LED is lit steadily. While the port is idle the LED is dark. Two fault conditions have their own count-coded flash patterns. An overcurrent fault gives a pair of long-on, short-off flashes that play once. An invalid detection signature gives a train of short-on, long-off flashes that ends in a long dark gap and then repeats. Each fault is reported to the block by a one-cycle strobe.

All pattern timing is counted in millisecond ticks, which arrive as a one-cycle clock enable. The default interval lengths are 223 ms, 74 ms and 1400 ms, and all three are parameters. A second, faster clock enable drives a 4-bit phase counter. When power saving is left on, the counter chops every lit interval to a 1/16 duty cycle, so a 400 kHz enable gives a 25 kHz pulse train. The control input that turns power saving off is active high, so tying it low keeps chopping on by default. The output `led_sink` is high whenever the open-drain pin should pull current through the LED.

Top module: `port_led_blinker`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `led_sink` is low and the block is in its idle mode.
- R2: From idle, a high `powered` level lights the LED steadily from the next cycle on. From the powered mode, a low `powered` level darkens the LED from the next cycle on.
- R3: An `oc_evt` strobe starts the overcurrent code from the next cycle. The code is OC_FLASHES repetitions of LONG_MS ticks lit followed by SHORT_MS ticks dark. After the last dark interval the LED follows `powered`: steady on if it is high, dark if it is low.
- R4: A `det_evt` strobe in idle starts the detection code from the next cycle. Each of the first DET_FLASHES-1 flashes is SHORT_MS ticks lit then LONG_MS ticks dark. The last flash is SHORT_MS ticks lit then GAP_MS ticks dark. The whole pattern then repeats without end.
- R5: A `det_evt` strobe while the detection code runs has no effect on its timing.
- R6: A rising edge of `powered` in any mode, including during either code, makes the LED steadily lit from the next cycle.
- R7: With `pwm_off` low, a lit interval drives `led_sink` high only while the 4-bit phase counter is 0. The counter starts at 0 after reset and advances by one, modulo 16, on each `pwm_tick`.
- R8: With `pwm_off` high, a lit interval drives `led_sink` high continuously, whatever `pwm_tick` does.
- R9: An `oc_evt` strobe during the detection code abandons that code and starts the overcurrent code. A `det_evt` strobe during the overcurrent code is ignored.
- R10: Interval timing advances only on `ms_tick`. Cycles without a tick leave the LED level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle enable, once per millisecond |
| pwm_tick | input | 1 | One-cycle enable that advances the PWM phase counter |
| powered | input | 1 | Port power is applied (level) |
| oc_evt | input | 1 | One-cycle strobe: overcurrent fault occurred |
| det_evt | input | 1 | One-cycle strobe: detection found an invalid signature |
| pwm_off | input | 1 | High disables duty-cycle chopping of lit intervals |
| led_sink | output | 1 | High when the LED pin should sink current |

## Verification
The bench shortens the intervals to a few ticks so that whole codes can be swept tick by tick against a schedule computed arithmetically. It runs the overcurrent code with the port unpowered and again with it powered. This separates the two return states. It runs two full periods of the detection code, which shows whether the long final gap is in place and whether the pattern repeats. It injects strobes during the detection code: a repeated detection strobe must not move the timing, an overcurrent strobe must restart the timing, and a power edge must give steady light. A long run of phase-counter ticks, with chopping on and then off, tells the 1/16 gate apart from plain level drive.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

    // Operating mode of the status LED sequencer
    typedef enum logic [1:0] {
        LM_IDLE  = 2'd0,
        LM_POWER = 2'd1,
        LM_OCF   = 2'd2,
        LM_DETF  = 2'd3
    } led_mode_e;

    // Half of a flash: lit interval or dark interval
    typedef enum logic {
        PH_LIT  = 1'b0,
        PH_DARK = 1'b1
    } led_half_e;

endpackage

// File: rtl/led_code_seq.sv
module led_code_seq
    import led_blink_pkg::*;
#(
    parameter int LONG_MS     = 223,
    parameter int SHORT_MS    = 74,
    parameter int GAP_MS      = 1400,
    parameter int OC_FLASHES  = 2,
    parameter int DET_FLASHES = 5
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ms_tick,
    input  logic      powered,
    input  logic      oc_evt,
    input  logic      det_evt,
    output led_mode_e mode,
    output logic      lit
);

    localparam int MAX_LS = (LONG_MS > SHORT_MS) ? LONG_MS : SHORT_MS;
    localparam int MAX_D  = (MAX_LS > GAP_MS) ? MAX_LS : GAP_MS;
    localparam int CW     = $clog2(MAX_D + 1);
    localparam int MAX_N  = (OC_FLASHES > DET_FLASHES) ? OC_FLASHES : DET_FLASHES;
    localparam int FW     = $clog2(MAX_N + 1);

    localparam logic [CW-1:0] LONG_END  = CW'(LONG_MS - 1);
    localparam logic [CW-1:0] SHORT_END = CW'(SHORT_MS - 1);
    localparam logic [CW-1:0] GAP_END   = CW'(GAP_MS - 1);
    localparam logic [FW-1:0] OC_LAST   = FW'(OC_FLASHES - 1);
    localparam logic [FW-1:0] DET_LAST  = FW'(DET_FLASHES - 1);

    typedef struct packed {
        led_mode_e       mode;
        led_half_e       half;
        logic [FW-1:0]   flash;
        logic [CW-1:0]   cnt;
        logic            pwr;
    } seq_st_t;

    seq_st_t s_d, s_q;

    logic          is_oc;
    logic          in_code;
    logic          last_flash;
    logic          span_done;
    logic          pwr_rise;
    logic [CW-1:0] span_end;

    function automatic seq_st_t launch(seq_st_t cur, led_mode_e m);
        seq_st_t r;
        r       = cur;
        r.mode  = m;
        r.half  = PH_LIT;
        r.flash = '0;
        r.cnt   = '0;
        return r;
    endfunction

    always_comb begin
        is_oc      = (s_q.mode == LM_OCF);
        in_code    = (s_q.mode == LM_OCF) || (s_q.mode == LM_DETF);
        last_flash = is_oc ? (s_q.flash == OC_LAST) : (s_q.flash == DET_LAST);
        if (s_q.half == PH_LIT) begin
            span_end = is_oc ? LONG_END : SHORT_END;
        end else begin
            span_end = is_oc ? SHORT_END : (last_flash ? GAP_END : LONG_END);
        end
        span_done = in_code && ms_tick && (s_q.cnt == span_end);
        pwr_rise  = powered && !s_q.pwr;

        s_d     = s_q;
        s_d.pwr = powered;

        // interval timing inside a code
        if (in_code && ms_tick) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        if (span_done) begin
            s_d.cnt = '0;
            if (s_q.half == PH_LIT) begin
                s_d.half = PH_DARK;
            end else begin
                s_d.half = PH_LIT;
                if (last_flash) begin
                    s_d.flash = '0;
                    if (is_oc) begin
                        s_d.mode = powered ? LM_POWER : LM_IDLE;
                    end
                end else begin
                    s_d.flash = s_q.flash + 1'b1;
                end
            end
        end

        // mode changes; a power edge wins over everything
        if (pwr_rise) begin
            s_d = launch(s_d, LM_POWER);
        end else begin
            unique case (s_q.mode)
                LM_IDLE: begin
                    if (powered)      s_d = launch(s_d, LM_POWER);
                    else if (oc_evt)  s_d = launch(s_d, LM_OCF);
                    else if (det_evt) s_d = launch(s_d, LM_DETF);
                end
                LM_POWER: begin
                    if (oc_evt)        s_d = launch(s_d, LM_OCF);
                    else if (!powered) s_d = launch(s_d, LM_IDLE);
                end
                LM_DETF: begin
                    if (oc_evt) s_d = launch(s_d, LM_OCF);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: LM_IDLE, half: PH_LIT, flash: '0, cnt: '0, pwr: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mode = s_q.mode;
    assign lit  = (s_q.mode == LM_POWER) ||
                  (((s_q.mode == LM_OCF) || (s_q.mode == LM_DETF)) && (s_q.half == PH_LIT));

endmodule

// File: rtl/led_pwm_chop.sv
module led_pwm_chop #(
    parameter int PWM_BITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic                bypass,
    input  logic                lit,
    output logic [PWM_BITS-1:0] phase,
    output logic                drive
);

    typedef struct packed {
        logic [PWM_BITS-1:0] ph;
    } chop_st_t;

    chop_st_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (step) begin
            c_d.ph = c_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{ph: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign phase = c_q.ph;
    assign drive = lit && (bypass || (c_q.ph == '0));

endmodule

// File: rtl/port_led_blinker.sv
module port_led_blinker
    import led_blink_pkg::*;
#(
    parameter int LONG_MS     = 223,
    parameter int SHORT_MS    = 74,
    parameter int GAP_MS      = 1400,
    parameter int OC_FLASHES  = 2,
    parameter int DET_FLASHES = 5,
    parameter int PWM_BITS    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic pwm_tick,
    input  logic powered,
    input  logic oc_evt,
    input  logic det_evt,
    input  logic pwm_off,
    output logic led_sink
);

    led_mode_e           seq_mode;
    logic                seq_lit;
    logic [PWM_BITS-1:0] pwm_phase;

    led_code_seq #(
        .LONG_MS    (LONG_MS),
        .SHORT_MS   (SHORT_MS),
        .GAP_MS     (GAP_MS),
        .OC_FLASHES (OC_FLASHES),
        .DET_FLASHES(DET_FLASHES)
    ) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ms_tick(ms_tick),
        .powered(powered),
        .oc_evt (oc_evt),
        .det_evt(det_evt),
        .mode   (seq_mode),
        .lit    (seq_lit)
    );

    led_pwm_chop #(
        .PWM_BITS(PWM_BITS)
    ) chop_i (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (pwm_tick),
        .bypass(pwm_off),
        .lit   (seq_lit),
        .phase (pwm_phase),
        .drive (led_sink)
    );

endmodule

// File: rtl/port_led_blinker_chk.sv
module port_led_blinker_chk
    import led_blink_pkg::*;
#(
    parameter int PB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          powered,
    input logic          pwm_off,
    input logic          led_sink,
    input led_mode_e     mode,
    input logic          lit,
    input logic [PB-1:0] phase
);

    // R1: dark while held in reset
    a_r1_reset_dark: assert property (@(posedge clk) !rst_n |-> !led_sink);

    // R2: idle mode never lights the pin
    a_r2_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_IDLE) |-> !led_sink);

    // R2: powered mode with chopping off is steadily lit at the pin
    a_r2_power_lit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_POWER && pwm_off) |-> led_sink);

    // R6: a power edge lands in powered mode next cycle
    a_r6_power_abort: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(powered) |=> (mode == LM_POWER));

    // R7: with chopping on, nonzero phase keeps the pin off
    a_r7_chop_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_off && phase != '0) |-> !led_sink);

    // R8: with chopping off, every lit interval reaches the pin
    a_r8_plain_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_off && lit) |-> led_sink);

endmodule

bind port_led_blinker port_led_blinker_chk #(.PB(PWM_BITS)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .powered (powered),
    .pwm_off (pwm_off),
    .led_sink(led_sink),
    .mode    (seq_mode),
    .lit     (seq_lit),
    .phase   (pwm_phase)
);

// File: tb/port_led_blinker_tb.sv
module port_led_blinker_tb_top;

    localparam int L  = 5;
    localparam int S  = 2;
    localparam int G  = 9;
    localparam int NO = 2;
    localparam int ND = 5;

    logic clk = 1'b0;
    logic rst_n, ms_tick, pwm_tick, powered, oc_evt, det_evt, pwm_off;
    logic led_sink;

    int n_chk  = 0;
    int n_fail = 0;
    int pwm_cnt = 0;

    always #2.5 clk = ~clk;

    port_led_blinker #(
        .LONG_MS(L), .SHORT_MS(S), .GAP_MS(G),
        .OC_FLASHES(NO), .DET_FLASHES(ND), .PWM_BITS(4)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pwm_tick(pwm_tick),
        .powered(powered), .oc_evt(oc_evt), .det_evt(det_evt),
        .pwm_off(pwm_off), .led_sink(led_sink)
    );

    task automatic check(input logic exp, input string req);
        n_chk++;
        if (led_sink !== exp) begin
            n_fail++;
            $display("FAIL %s: led_sink=%0b expected=%0b at %0t", req, led_sink, exp, $time);
        end
    endtask

    // expected overcurrent-code level j ticks after entry
    function automatic logic exp_oc(input int j, input logic pwr);
        if (j >= NO * (L + S)) return pwr;
        return (j % (L + S)) < L;
    endfunction

    // expected detection-code level j ticks after entry
    function automatic logic exp_det(input int j);
        int body = (ND - 1) * (S + L);
        int r    = j % (body + S + G);
        if (r < body) return (r % (S + L)) < S;
        return (r - body) < S;
    endfunction

    task automatic ms_step();
        @(negedge clk) ms_tick = 1'b1;
        @(negedge clk) ms_tick = 1'b0;
    endtask

    task automatic pwm_step();
        @(negedge clk) pwm_tick = 1'b1;
        @(negedge clk) pwm_tick = 1'b0;
        pwm_cnt++;
    endtask

    task automatic strobe_oc();
        @(negedge clk) oc_evt = 1'b1;
        @(negedge clk) oc_evt = 1'b0;
    endtask

    task automatic strobe_det();
        @(negedge clk) det_evt = 1'b1;
        @(negedge clk) det_evt = 1'b0;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; ms_tick = 1'b0; pwm_tick = 1'b0; powered = 1'b0;
        oc_evt = 1'b0; det_evt = 1'b0; pwm_off = 1'b1;
        repeat (4) @(negedge clk);
        check(1'b0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, "R1 after reset");

        // R2: steady on while powered, off when dropped
        powered = 1'b1;
        @(negedge clk);
        check(1'b1, "R2 power on");
        for (int k = 0; k < 6; k++) begin
            ms_step();
            check(1'b1, "R2 steady on");
        end
        powered = 1'b0;
        @(negedge clk);
        check(1'b0, "R2 power off");

        // R10: no tick, no change
        repeat (5) @(negedge clk);
        check(1'b0, "R10 idle hold");

        // R3: overcurrent code, port unpowered at end
        strobe_oc();
        check(exp_oc(0, 1'b0), "R3 oc entry");
        repeat (7) @(negedge clk);
        check(exp_oc(0, 1'b0), "R10 oc hold without tick");
        for (int j = 1; j <= NO * (L + S) + 3; j++) begin
            ms_step();
            check(exp_oc(j, 1'b0), "R3 oc unpowered");
        end

        // R3: overcurrent while powered stays high, returns to steady on
        powered = 1'b1;
        @(negedge clk);
        strobe_oc();
        check(exp_oc(0, 1'b1), "R3 oc entry powered");
        for (int j = 1; j <= NO * (L + S) + 3; j++) begin
            ms_step();
            check(exp_oc(j, 1'b1), "R3 oc powered");
        end
        powered = 1'b0;
        @(negedge clk);
        check(1'b0, "R2 back to idle");

        // R4 and R5: detection code over two periods, restrobe mid-way
        strobe_det();
        check(exp_det(0), "R4 det entry");
        for (int j = 1; j <= 2 * ((ND - 1) * (S + L) + S + G) + 3; j++) begin
            ms_step();
            check(exp_det(j), "R4 det pattern");
            if (j == 10 || j == 45) begin
                strobe_det();
                check(exp_det(j), "R5 det restrobe ignored");
            end
        end

        // R6: power edge aborts the detection code
        powered = 1'b1;
        @(negedge clk);
        check(1'b1, "R6 abort to steady on");
        ms_step();
        check(1'b1, "R6 stays on");
        powered = 1'b0;
        @(negedge clk);
        check(1'b0, "R2 idle after abort");

        // R9: overcurrent preempts detection; detection ignored during overcurrent
        strobe_det();
        for (int j = 1; j <= 4; j++) begin
            ms_step();
            check(exp_det(j), "R4 det before preempt");
        end
        strobe_oc();
        check(exp_oc(0, 1'b0), "R9 oc preempts det");
        for (int j = 1; j <= NO * (L + S) + 3; j++) begin
            ms_step();
            check(exp_oc(j, 1'b0), "R9 oc after preempt");
            if (j == 3) begin
                strobe_det();
                check(exp_oc(j, 1'b0), "R9 det ignored in oc");
            end
        end

        // R7: chopping on while powered
        pwm_off = 1'b0;
        powered = 1'b1;
        @(negedge clk);
        check((pwm_cnt % 16) == 0, "R7 chop phase start");
        for (int k = 0; k < 40; k++) begin
            pwm_step();
            check((pwm_cnt % 16) == 0, "R7 chop gate");
        end

        // R8: chopping off, level drive through many phases
        pwm_off = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            pwm_step();
            check(1'b1, "R8 plain level");
        end
        powered = 1'b0;
        @(negedge clk);
        check(1'b0, "R2 final off");

        finish_run();
    end

endmodule